// File: doc/BRIEF.md
# Vector Lane Broadcast Unit

This block takes one scalar lane out of a 64-bit source register and copies it into every lane of a destination vector. A 4-bit immediate encodes both the lane width and the lane number. The lowest set bit of the immediate selects the width, and the bits above it give the index. A destination-select input chooses a 64-bit or a 128-bit destination. For the narrow destination the upper half of the 128-bit result is held at zero. A write-width output tells the register writeback stage how many bits to commit.

The datapath is purely combinational. It sits in a valid/ready stream with no storage:
- `out_valid` follows `in_valid` and `in_ready` follows `out_ready` in the same cycle.
- A producer stalled by `out_ready` low must hold `src`, `imm` and `quad_dst` steady. The result then stays steady until the consumer accepts it.
- While `rst_n` is low both `out_valid` and `in_ready` are low.

An immediate of zero encodes no lane width. It raises an illegal-encoding flag and forces the result to zero.

Top module: `lane_broadcast_unit`

## Requirements
- R1: When `imm[0]` is 1 the lane is 8 bits wide and its index is `imm[3:1]`. The selected byte is `src[8*index +: 8]`, and every byte of every written word equals it.
- R2: When `imm[1:0]` is 2'b10 the lane is 16 bits wide and its index is `imm[3:2]`. The selected halfword is `src[16*index +: 16]`, and every halfword of every written word equals it.
- R3: When `imm[1:0]` is 2'b00 and `imm` is nonzero the lane is 32 bits wide and its index is `imm[3]`. Every written word equals `src[32*index +: 32]`.
- R4: When `quad_dst` is 1, all four 32-bit words of `result` are equal and `wide_write` is 1, meaning 128 bits.
- R5: When `quad_dst` is 0, `result[127:64]` is zero, the two low words are equal, and `wide_write` is 0, meaning 64 bits.
- R6: When `imm` is 4'b0000, `illegal` is 1 and `result` is all zero for either destination. For any nonzero `imm`, `illegal` is 0.
- R7: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` combinationally. With inputs held during a stall, `result` stays unchanged.
- R8: While `rst_n` is low, `out_valid` and `in_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only for the property checks |
| rst_n | input | 1 | Active-low reset; blocks the handshake |
| in_valid | input | 1 | Upstream has a broadcast request |
| in_ready | output | 1 | Block can accept the request |
| src | input | 64 | Source register holding the lanes |
| imm | input | 4 | Lane width and index encoding |
| quad_dst | input | 1 | 1 selects the 128-bit destination, 0 the 64-bit one |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Downstream accepts the result |
| result | output | 128 | Broadcast vector |
| wide_write | output | 1 | 1 means a 128-bit write, 0 a 64-bit write |
| illegal | output | 1 | Immediate encodes no lane width |

## Verification
The hardest cases to reach are the immediates whose high bits overlap the width field. Examples are 4'b1100, which must still select a 32-bit lane with index 1, and 4'b1010, which selects halfword 2. The stimulus table lists these next to the plain cases. It uses two sources whose bytes are all distinct, so that a wrong shift amount or a wrong index shows up as a wrong byte. The directed tests then cover the zero immediate with both destination widths, and a stall with `out_ready` low while the inputs are held.

// File: rtl/lane_bcast_pkg.sv
package lane_bcast_pkg;
  // Lane width selected by the lowest set bit of the immediate
  typedef enum logic [1:0] {
    LSZ_NONE = 2'd0,
    LSZ_8    = 2'd1,
    LSZ_16   = 2'd2,
    LSZ_32   = 2'd3
  } lane_sz_e;

  localparam int NUM_LANE_SIZES = 3;  // 8, 16, 32
  localparam int MIN_LANE_W     = 8;
endpackage

// File: rtl/lbc_imm_decode.sv
module lbc_imm_decode
  import lane_bcast_pkg::*;
#(
  parameter int IMM_W = 4,
  localparam int IDX_W = IMM_W - 1
) (
  input  logic [IMM_W-1:0] imm,
  output lane_sz_e         sz,
  output logic [IDX_W-1:0] idx,
  output logic             illegal
);
  // Lowest set bit chooses the width; the bits above it form the index.
  always_comb begin
    sz      = LSZ_NONE;
    idx     = '0;
    illegal = 1'b0;
    if (imm[0]) begin
      sz  = LSZ_8;
      idx = IDX_W'(imm >> 1);
    end else if (imm[1]) begin
      sz  = LSZ_16;
      idx = IDX_W'(imm >> 2);
    end else if (imm != '0) begin
      sz  = LSZ_32;
      idx = IDX_W'(imm >> 3);
    end else begin
      illegal = 1'b1;
    end
  end
endmodule

// File: rtl/lbc_lane_pick.sv
module lbc_lane_pick
  import lane_bcast_pkg::*;
#(
  parameter int SRC_W  = 64,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic [SRC_W-1:0]  src,
  input  lane_sz_e          sz,
  input  logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] scalar
);
  logic [WORD_W-1:0] cand [NUM_LANE_SIZES];

  // One candidate extractor per lane width, each masked to its width
  for (genvar g = 0; g < NUM_LANE_SIZES; g++) begin : g_size
    localparam int LW = MIN_LANE_W << g;
    logic [SRC_W-1:0] shifted;
    always_comb begin
      shifted = src >> (int'(idx) * LW);
      cand[g] = '0;
      cand[g][LW-1:0] = shifted[LW-1:0];
    end
  end

  always_comb begin
    unique case (sz)
      LSZ_8:   scalar = cand[0];
      LSZ_16:  scalar = cand[1];
      LSZ_32:  scalar = cand[2];
      default: scalar = '0;
    endcase
  end
endmodule

// File: rtl/lbc_word_fill.sv
module lbc_word_fill
  import lane_bcast_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] scalar,
  input  lane_sz_e          sz,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] rep [NUM_LANE_SIZES];

  // Replicate the scalar across the word for each lane width
  for (genvar g = 0; g < NUM_LANE_SIZES; g++) begin : g_rep
    localparam int LW = MIN_LANE_W << g;
    localparam int NL = WORD_W / LW;
    assign rep[g] = {NL{scalar[LW-1:0]}};
  end

  always_comb begin
    unique case (sz)
      LSZ_8:   word = rep[0];
      LSZ_16:  word = rep[1];
      LSZ_32:  word = rep[2];
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/lane_broadcast_unit.sv
module lane_broadcast_unit
  import lane_bcast_pkg::*;
#(
  parameter int SRC_W  = 64,
  parameter int OUT_W  = 128,
  parameter int IMM_W  = 4,
  parameter int WORD_W = 32,
  localparam int IDX_W   = IMM_W - 1,
  localparam int N_WORDS = OUT_W / WORD_W,
  localparam int N_HALF  = SRC_W / WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SRC_W-1:0] src,
  input  logic [IMM_W-1:0] imm,
  input  logic             quad_dst,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] result,
  output logic             wide_write,
  output logic             illegal
);
  lane_sz_e          sz;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] scalar;
  logic [WORD_W-1:0] word;

  lbc_imm_decode #(.IMM_W(IMM_W)) u_dec (
    .imm(imm), .sz(sz), .idx(idx), .illegal(illegal)
  );

  lbc_lane_pick #(.SRC_W(SRC_W), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_pick (
    .src(src), .sz(sz), .idx(idx), .scalar(scalar)
  );

  lbc_word_fill #(.WORD_W(WORD_W)) u_fill (
    .scalar(scalar), .sz(sz), .word(word)
  );

  // Stream pass-through: no storage, reset blocks the handshake
  assign out_valid  = rst_n & in_valid;
  assign in_ready   = rst_n & out_ready;
  assign wide_write = quad_dst;

  // Word placement: low half always written, upper half only for quad
  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    localparam bit IS_LOW = (k < N_HALF);
    always_comb begin
      if (illegal)
        result[k*WORD_W +: WORD_W] = '0;
      else if (IS_LOW || quad_dst)
        result[k*WORD_W +: WORD_W] = word;
      else
        result[k*WORD_W +: WORD_W] = '0;
    end
  end

  // R1: byte lane matches source byte at index imm[3:1]
  a_r1_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && imm[0] |->
      result[7:0] == 8'(src >> (int'(imm[3:1]) * 8)) && result[15:8] == result[7:0]);

  // R2: halfword lane matches source halfword at index imm[3:2]
  a_r2_half_lane: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && imm[1:0] == 2'b10 |->
      result[15:0] == 16'(src >> (int'(imm[3:2]) * 16)) && result[31:16] == result[15:0]);

  // R3: word lane matches source word at index imm[3]
  a_r3_word_lane: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && imm[1:0] == 2'b00 && imm != '0 |->
      result[31:0] == 32'(src >> (int'(imm[3]) * 32)));

  // R4: quad destination fills all words equally
  a_r4_quad_fill: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && quad_dst |->
      wide_write && result[127:96] == result[31:0] && result[95:64] == result[31:0]
      && result[63:32] == result[31:0]);

  // R5: double destination keeps the upper half at zero
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !quad_dst |->
      !wide_write && result[127:64] == '0 && result[63:32] == result[31:0]);

  // R6: zero immediate flags illegal and drives zero
  a_r6_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    imm == '0 |-> illegal && result == '0);

  // R7: held inputs during a stall keep the result steady
  a_r7_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && $stable(src) && $stable(imm) && $stable(quad_dst)
      |-> $stable(result));

  // R8: no handshake activity in reset
  always_comb begin
    if (!rst_n) a_r8_reset_idle: assert (!out_valid && !in_ready);
  end
endmodule

// File: tb/lane_broadcast_unit_test.sv
module lane_broadcast_unit_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready, out_valid, out_ready;
  logic [63:0]  src;
  logic [3:0]   imm;
  logic         quad_dst;
  logic [127:0] result;
  logic         wide_write, illegal;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lane_broadcast_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src(src), .imm(imm), .quad_dst(quad_dst), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .wide_write(wide_write),
    .illegal(illegal)
  );

  localparam logic [63:0] SA = 64'h8877_6655_4433_2211;
  localparam logic [63:0] SB = 64'hFEDC_BA98_7654_3210;
  localparam int NV = 16;
  // {src, imm, quad, expected replicated word}
  localparam logic [100:0] VEC [NV] = '{
    {SA, 4'd1,  1'b1, 32'h1111_1111},  // R1 byte 0
    {SA, 4'd3,  1'b0, 32'h2222_2222},  // R1 byte 1
    {SA, 4'd15, 1'b1, 32'h8888_8888},  // R1 byte 7
    {SA, 4'd9,  1'b0, 32'h5555_5555},  // R1 byte 4
    {SB, 4'd13, 1'b1, 32'hDCDC_DCDC},  // R1 byte 6
    {SB, 4'd7,  1'b0, 32'h7676_7676},  // R1 byte 3
    {SA, 4'd2,  1'b1, 32'h2211_2211},  // R2 half 0
    {SA, 4'd6,  1'b0, 32'h4433_4433},  // R2 half 1
    {SA, 4'd14, 1'b1, 32'h8877_8877},  // R2 half 3
    {SA, 4'd10, 1'b0, 32'h6655_6655},  // R2 half 2
    {SB, 4'd6,  1'b1, 32'h7654_7654},  // R2 half 1
    {SA, 4'd4,  1'b1, 32'h4433_2211},  // R3 word 0
    {SA, 4'd8,  1'b0, 32'h8877_6655},  // R3 word 1
    {SA, 4'd12, 1'b1, 32'h8877_6655},  // R3 word 1 via 4'b1100
    {SB, 4'd8,  1'b1, 32'hFEDC_BA98},  // R3 word 1
    {SB, 4'd4,  1'b0, 32'h7654_3210}   // R3 word 0
  };

  task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] expect_vec(input logic [31:0] w, input logic q);
    return q ? {w, w, w, w} : {64'h0, w, w};
  endfunction

  task automatic apply(input logic [63:0] s, input logic [3:0] i, input logic q);
    @(negedge clk);
    src = s; imm = i; quad_dst = q;
    #1;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b1; out_ready = 1'b1;
    src = SA; imm = 4'd1; quad_dst = 1'b1;
    #12;
    // R8: reset blocks the handshake
    chk({126'h0, out_valid, in_ready}, 128'h0, "R8");
    @(negedge clk); rst_n = 1'b1;

    for (int n = 0; n < NV; n++) begin
      logic [100:0] v;
      string tag;
      v = VEC[n];
      apply(v[100:37], v[36:33], v[32]);
      tag = (v[33] ? "R1" : (v[34] ? "R2" : "R3"));
      chk(result, expect_vec(v[31:0], v[32]), tag);
      chk({127'h0, wide_write}, {127'h0, v[32]}, v[32] ? "R4" : "R5");
      chk({127'h0, illegal}, 128'h0, "R6");
    end

    // R6: zero immediate, both destination widths
    apply(SB, 4'd0, 1'b1);
    chk(result, 128'h0, "R6");
    chk({127'h0, illegal}, 128'h1, "R6");
    apply(SA, 4'd0, 1'b0);
    chk(result, 128'h0, "R6");
    chk({127'h0, wide_write}, 128'h0, "R5");

    // R7: stall with held inputs, pass-through handshake
    apply(SB, 4'd5, 1'b1);
    out_ready = 1'b0; #1;
    chk({126'h0, out_valid, in_ready}, 128'h2, "R7");
    @(negedge clk); #1;
    chk(result, expect_vec(32'h5454_5454, 1'b1), "R7");
    in_valid = 1'b0; out_ready = 1'b1; #1;
    chk({126'h0, out_valid, in_ready}, 128'h1, "R7");

    // R8: reset reasserted mid-stream
    in_valid = 1'b1; rst_n = 1'b0; #1;
    chk({126'h0, out_valid, in_ready}, 128'h0, "R8");
    rst_n = 1'b1;

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule